// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, frame by frame, whether a receiver should keep an incoming Ethernet frame. It looks only at the destination address. The six destination bytes arrive as a byte stream with a valid/ready handshake. The block computes a reflected CRC-32 over those bytes as they arrive, so the multicast hash index is ready on the same edge as the last byte. One cycle after the sixth byte, it reports a single-cycle decision strobe together with an accept flag.

A host programs the block through a byte-wide register port with four registers:

- **Change control**: opens and closes an address-change session.
- **Station data port**: takes the 48-bit station address one byte per write.
- **Hash data port**: takes the 64-bit multicast hash filter one byte per write.
- **MAC control**: holds the receive-enable, transmit-enable and promiscuous bits.

Each data port has its own load pointer. The pointers are reset from the change-control register. Opening a session makes the block busy for a short, self-clearing interval. While the block is busy, and at any time outside a session, writes to the data ports are ignored. Every accepted write to either table switches the receiver and transmitter enables off. They stay off until software writes the MAC control register again.

Back-pressure rule for the destination stream: a byte transfers on a clock edge where `da_valid` and `da_ready` are both high. The block drops `da_ready` only in the cycle in which it presents a decision, so each frame costs one bubble cycle. Holding `da_valid` through that cycle is allowed; the byte waits. A byte with `da_sof` set always restarts the address field and the CRC.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `rx_enable`, `tx_enable`, the promiscuous bit and `dec_valid` are 0. `da_ready` is 1, and both change control (address 0) and MAC control (address 3) read 0.
- R2: A write to address 0 with bit 2 set opens a session. Bit 2 of address 0 then reads 1 for exactly two cycles and 0 afterwards. In that same write, bit 1 set zeroes the station load pointer and bit 0 set zeroes the hash load pointer.
- R3: A write to a data port (address 1 or 2) while bit 2 of address 0 reads 1, or while no session is open, is ignored. Such a write changes neither the tables nor the enables.
- R4: Station writes to address 1 fill destination byte 0 first (the first byte on the wire), then bytes 1 to 5. The pointer wraps from byte 5 back to byte 0.
- R5: Eight hash writes to address 2 fill filter byte n with filter bits 8n+7..8n. Filter bit k is therefore hash word k[5:4], bit k[3:0], with word 0 held in bytes 0 and 1, low byte first.
- R6: Writing 0 to address 0 closes the session. Later data-port writes are ignored.
- R7: Every accepted data-port write clears `rx_enable` and `tx_enable` in the next cycle. A write to address 3 sets receive enable from bit 0, transmit enable from bit 1 and promiscuous mode from bit 2, exactly as written.
- R8: A frame whose first destination byte has bit 0 clear is accepted only if all 48 bits equal the station address.
- R9: The broadcast address (all ones) is accepted whatever the hash filter holds.
- R10: A frame whose first destination byte has bit 0 set is accepted when filter bit k is 1. Here k is bits 31..26 of a CRC-32 over the six bytes, with polynomial 0xEDB88320, each byte shifted in LSB first, initial value all ones and no final inversion. An all-ones filter therefore accepts every group address, and an all-zeros filter rejects every one except broadcast.
- R11: With promiscuous mode set, every frame is accepted.
- R12: `dec_valid` pulses for exactly one cycle, the cycle after the sixth byte transfers, and `da_ready` is 0 in that cycle. A byte with `da_sof` set restarts the count, so a truncated field produces no decision.
- R13: With receive enable clear, `dec_accept` is 0 on every decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 change control, 1 station data, 2 hash data, 3 MAC control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| da_valid | input | 1 | Destination byte valid |
| da_sof | input | 1 | Byte is destination byte 0 of a new frame |
| da_byte | input | 8 | Destination byte |
| da_ready | output | 1 | Block can take a destination byte |
| rx_enable | output | 1 | Receiver enable |
| tx_enable | output | 1 | Transmitter enable |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Frame accepted; meaningful when `dec_valid` is 1 |

## Verification
The bench drives both the register port and the destination stream, and every check is made at the ports. Each kind of internal fault shows up differently:

- **Wrong load pointer or byte lane.** Nothing is visible while the tables load. The fault appears on the next frame's decision, exactly one cycle after its sixth byte: a station address that should match is rejected, or a hash bit lands on the wrong index.
- **Miscounting busy counter or session flag.** This shows on the busy bit read back within three cycles, and through a stray write that later flips a decision or drops the enables.
- **Stale CRC or byte count across an `da_sof` restart.** This shows as a missing, early or wrong decision on the frame that follows.

// File: rtl/raf_pkg.sv
package raf_pkg;
  typedef enum logic [1:0] {
    REG_CFG = 2'd0,
    REG_STA = 2'd1,
    REG_FLT = 2'd2,
    REG_MAC = 2'd3
  } raf_reg_e;

  localparam int CFG_LRST = 0;
  localparam int CFG_PRST = 1;
  localparam int CFG_CHG  = 2;

  localparam int MAC_RXEN = 0;
  localparam int MAC_TXEN = 1;
  localparam int MAC_PROM = 2;

  // One byte of a reflected CRC, LSB of the byte first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c,
                                           input logic [7:0]  d,
                                           input logic [31:0] poly);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/raf_regs.sv
module raf_regs
  import raf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int FILT_BYTES = 8,
  parameter int BUSY_CYC   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [1:0]              reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  output logic [8*ADDR_BYTES-1:0] station,
  output logic [8*FILT_BYTES-1:0] filter,
  output logic                    promisc,
  output logic                    rx_en,
  output logic                    tx_en,
  output logic                    busy,
  output logic                    data_take
);
  localparam int SPW = $clog2(ADDR_BYTES);
  localparam int LPW = $clog2(FILT_BYTES);
  localparam int BCW = $clog2(BUSY_CYC + 1);

  logic [BCW-1:0] bcnt;
  logic           sess;
  logic [SPW-1:0] sptr;
  logic [LPW-1:0] lptr;
  logic           cfg_wr, mac_wr, sta_take, flt_take;

  assign busy      = (bcnt != '0);
  assign cfg_wr    = reg_wr && (reg_addr == REG_CFG);
  assign mac_wr    = reg_wr && (reg_addr == REG_MAC);
  assign sta_take  = reg_wr && (reg_addr == REG_STA) && sess && !busy;
  assign flt_take  = reg_wr && (reg_addr == REG_FLT) && sess && !busy;
  assign data_take = sta_take || flt_take;

  // session, busy window and load pointers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0;
      sess <= 1'b0;
      sptr <= '0;
      lptr <= '0;
    end else if (cfg_wr) begin
      sess <= reg_wdata[CFG_CHG];
      bcnt <= reg_wdata[CFG_CHG] ? BCW'(BUSY_CYC) : '0;
      if (reg_wdata[CFG_PRST]) sptr <= '0;
      if (reg_wdata[CFG_LRST]) lptr <= '0;
    end else begin
      if (busy) bcnt <= bcnt - 1'b1;
      if (sta_take) sptr <= (sptr == SPW'(ADDR_BYTES - 1)) ? '0 : sptr + 1'b1;
      if (flt_take) lptr <= (lptr == LPW'(FILT_BYTES - 1)) ? '0 : lptr + 1'b1;
    end
  end

  // table storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      station <= '0;
      filter  <= '0;
    end else begin
      if (sta_take) station[sptr*8 +: 8] <= reg_wdata;
      if (flt_take) filter[lptr*8 +: 8]  <= reg_wdata;
    end
  end

  // MAC control with auto-disable on table change
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      promisc <= 1'b0;
    end else if (mac_wr) begin
      rx_en   <= reg_wdata[MAC_RXEN];
      tx_en   <= reg_wdata[MAC_TXEN];
      promisc <= reg_wdata[MAC_PROM];
    end else if (data_take) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CFG: reg_rdata[CFG_CHG] = busy;
      REG_MAC: begin
        reg_rdata[MAC_RXEN] = rx_en;
        reg_rdata[MAC_TXEN] = tx_en;
        reg_rdata[MAC_PROM] = promisc;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/raf_hash.sv
module raf_hash
  import raf_pkg::*;
#(
  parameter logic [31:0] POLY = 32'hEDB8_8320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        first,
  input  logic [7:0]  din,
  output logic [31:0] crc_next
);
  logic [31:0] crc_q;

  assign crc_next = crc_byte(first ? '1 : crc_q, din, POLY);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= '1;
    else if (step) crc_q <= crc_next;
  end
endmodule

// File: rtl/raf_match.sv
module raf_match #(
  parameter int ADDR_BYTES = 6,
  parameter int FILT_BYTES = 8,
  parameter int HW         = $clog2(8 * FILT_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    da_valid,
  input  logic                    da_sof,
  input  logic [7:0]              da_byte,
  output logic                    da_ready,
  output logic                    step,
  output logic                    first,
  input  logic [HW-1:0]           hidx,
  input  logic [8*ADDR_BYTES-1:0] station,
  input  logic [8*FILT_BYTES-1:0] filter,
  input  logic                    promisc,
  input  logic                    rx_en,
  output logic                    dec_valid,
  output logic                    dec_accept
);
  localparam int CW = $clog2(ADDR_BYTES);

  logic [CW-1:0]             cnt, idx;
  logic [8*ADDR_BYTES-1:0]   da_q, da_full;
  logic                      last, grp, bcast, uni_hit, hash_hit, hit;

  assign da_ready = !dec_valid;
  assign step     = da_valid && da_ready;
  assign first    = da_sof || (cnt == '0);
  assign idx      = da_sof ? '0 : cnt;
  assign last     = (idx == CW'(ADDR_BYTES - 1));

  always_comb begin
    da_full = da_q;
    da_full[idx*8 +: 8] = da_byte;
  end

  assign grp      = da_full[0];
  assign bcast    = &da_full;
  assign uni_hit  = (da_full == station);
  assign hash_hit = filter[hidx];
  assign hit      = promisc || (grp ? (bcast || hash_hit) : uni_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      da_q       <= '0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= step && last;
      dec_accept <= step && last && rx_en && hit;
      if (step) begin
        cnt  <= last ? '0 : idx + 1'b1;
        da_q <= da_full;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          FILT_BYTES = 8,
  parameter int          BUSY_CYC   = 2,
  parameter logic [31:0] CRC_POLY   = 32'hEDB8_8320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       da_valid,
  input  logic       da_sof,
  input  logic [7:0] da_byte,
  output logic       da_ready,
  output logic       rx_enable,
  output logic       tx_enable,
  output logic       dec_valid,
  output logic       dec_accept
);
  localparam int HW = $clog2(8 * FILT_BYTES);

  logic [8*ADDR_BYTES-1:0] station;
  logic [8*FILT_BYTES-1:0] filter;
  logic                    promisc, chg_busy, data_take, step, first;
  logic [31:0]             crc_next;

  raf_regs #(.ADDR_BYTES(ADDR_BYTES), .FILT_BYTES(FILT_BYTES), .BUSY_CYC(BUSY_CYC)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .station, .filter, .promisc,
    .rx_en(rx_enable), .tx_en(tx_enable),
    .busy(chg_busy), .data_take
  );

  raf_hash #(.POLY(CRC_POLY)) u_hash (
    .clk, .rst_n, .step, .first, .din(da_byte), .crc_next
  );

  raf_match #(.ADDR_BYTES(ADDR_BYTES), .FILT_BYTES(FILT_BYTES), .HW(HW)) u_match (
    .clk, .rst_n, .da_valid, .da_sof, .da_byte, .da_ready, .step, .first,
    .hidx(crc_next[31 -: HW]), .station, .filter, .promisc,
    .rx_en(rx_enable), .dec_valid, .dec_accept
  );
endmodule

// File: rtl/raf_checker.sv
module raf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       chg_bit,
  input logic       chg_busy,
  input logic       data_take,
  input logic       rx_enable,
  input logic       tx_enable,
  input logic       da_ready,
  input logic       dec_valid,
  input logic       dec_accept
);
  logic open_wr;
  assign open_wr = reg_wr && (reg_addr == 2'd0) && chg_bit;

  assert_busy_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    open_wr |=> chg_busy);

  assert_busy_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_busy && $past(chg_busy) && !open_wr) |=> !chg_busy);

  assert_no_take_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chg_busy |-> !data_take);

  assert_autodisable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> (!rx_enable && !tx_enable));

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_bubble_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !da_ready);

  assert_rx_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> (dec_valid && $past(rx_enable)));
endmodule

bind rx_addr_filter raf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .chg_bit(reg_wdata[2]), .chg_busy(chg_busy), .data_take(data_take),
  .rx_enable(rx_enable), .tx_enable(tx_enable), .da_ready(da_ready),
  .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       da_valid = 1'b0;
  logic       da_sof = 1'b0;
  logic [7:0] da_byte = 8'd0;
  logic       da_ready, rx_enable, tx_enable, dec_valid, dec_accept;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .da_valid, .da_sof, .da_byte, .da_ready,
    .rx_enable, .tx_enable, .dec_valid, .dec_accept
  );

  localparam logic [47:0] STA   = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
  localparam logic [47:0] MCAST = {8'h01, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
  localparam logic [47:0] MC2   = {8'h9A, 8'h78, 8'h56, 8'h34, 8'h12, 8'h33};
  localparam logic [47:0] BCAST = '1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected hash index: bit-serial CRC over 48 bits, LSB of each byte first
  function automatic int hash_of(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return int'(c[31:26]);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic open_sess(input logic [7:0] resets);
    wr(2'd0, 8'h04 | resets);
    repeat (2) @(negedge clk);
  endtask

  task automatic load_station(input logic [47:0] s);
    open_sess(8'h02);
    for (int i = 0; i < 6; i++) wr(2'd1, s[8*i +: 8]);
    wr(2'd0, 8'h00);
  endtask

  task automatic load_filter(input logic [63:0] f);
    open_sess(8'h01);
    for (int i = 0; i < 8; i++) wr(2'd2, f[8*i +: 8]);
    wr(2'd0, 8'h00);
  endtask

  task automatic send(input logic [47:0] a, output logic acc, input string req);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_sof = (i == 0); da_byte = a[8*i +: 8];
    end
    @(negedge clk);
    da_valid = 1'b0; da_sof = 1'b0;
    #1;
    chk({req, " decision strobe"}, dec_valid, 1);
    chk({req, " R12 ready low on strobe"}, da_ready, 0);
    acc = dec_accept;
    @(negedge clk);
    #1 chk({req, " R12 strobe one cycle"}, dec_valid, 0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    #1;
    chk("R1 rx_enable", rx_enable, 0);
    chk("R1 tx_enable", tx_enable, 0);
    chk("R1 dec_valid", dec_valid, 0);
    chk("R1 da_ready", da_ready, 1);
    rd(2'd0, d); chk("R1 cfg read", d, 0);
    rd(2'd3, d); chk("R1 mac read", d, 0);
  endtask

  task automatic t_busy;
    logic [7:0] d;
    wr(2'd0, 8'h07);
    rd(2'd0, d); chk("R2 busy cycle 1", d[2], 1);
    @(negedge clk); rd(2'd0, d); chk("R2 busy cycle 2", d[2], 1);
    @(negedge clk); rd(2'd0, d); chk("R2 busy cleared", d[2], 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_station;
    logic acc; logic [7:0] d;
    wr(2'd3, 8'h03);
    load_station(STA);
    rd(2'd3, d); chk("R7 mac bits cleared by load", d, 0);
    #1 chk("R7 rx_enable off", rx_enable, 0);
    chk("R7 tx_enable off", tx_enable, 0);
    wr(2'd3, 8'h03);
    rd(2'd3, d); chk("R7 mac written", d, 8'h03);
    send(STA, acc, "R8 exact"); chk("R8 exact match accepted", acc, 1);
    send(STA ^ 48'h0100_0000_0000, acc, "R8 miss");
    chk("R8 last byte mismatch rejected", acc, 0);
  endtask

  task automatic t_ignore;
    logic acc; logic [7:0] d;
    // write during busy window
    wr(2'd0, 8'h06);
    wr(2'd1, 8'hEE);
    @(negedge clk);
    wr(2'd0, 8'h00);
    // write outside any session
    wr(2'd1, 8'hEE);
    wr(2'd2, 8'hFF);
    rd(2'd3, d); chk("R3 R6 enables kept", d, 8'h03);
    send(STA, acc, "R3 station kept"); chk("R3 ignored writes left station", acc, 1);
    send(MCAST, acc, "R6 filter kept"); chk("R6 write after close ignored", acc, 0);
  endtask

  task automatic t_wrap;
    logic acc;
    open_sess(8'h02);
    for (int i = 0; i < 6; i++) wr(2'd1, STA[8*i +: 8]);
    wr(2'd1, 8'h76);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h03);
    send({STA[47:8], 8'h76}, acc, "R4 wrap"); chk("R4 seventh write lands in byte 0", acc, 1);
    load_station(STA);
    wr(2'd3, 8'h03);
  endtask

  task automatic t_hash;
    logic acc; logic [63:0] f;
    int k;
    k = hash_of(MCAST);
    f = '0; f[k] = 1'b1;
    load_filter(f); wr(2'd3, 8'h03);
    send(MCAST, acc, "R10 set"); chk("R5 R10 hash bit set accepted", acc, 1);
    f = '0; f[k ^ 1] = 1'b1;
    load_filter(f); wr(2'd3, 8'h03);
    send(MCAST, acc, "R10 neighbour"); chk("R5 R10 neighbour bit rejects", acc, 0);
    load_filter('1); wr(2'd3, 8'h03);
    send(MC2, acc, "R10 ones"); chk("R10 all-ones filter accepts", acc, 1);
    load_filter('0); wr(2'd3, 8'h03);
    send(MC2, acc, "R10 zeros"); chk("R10 all-zeros filter rejects", acc, 0);
    send(BCAST, acc, "R9"); chk("R9 broadcast accepted with empty filter", acc, 1);
  endtask

  task automatic t_promisc;
    logic acc;
    wr(2'd3, 8'h07);
    send(48'h0000_0000_0A00, acc, "R11 uni"); chk("R11 foreign unicast accepted", acc, 1);
    send(MC2, acc, "R11 multi"); chk("R11 unmatched group accepted", acc, 1);
    wr(2'd3, 8'h03);
  endtask

  task automatic t_sof_restart;
    logic acc;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_sof = (i == 0); da_byte = 8'hC0 + 8'(i);
    end
    @(negedge clk);
    da_valid = 1'b0; da_sof = 1'b0;
    #1 chk("R12 no decision for truncated field", dec_valid, 0);
    send(STA, acc, "R12 restart"); chk("R12 sof restarts field", acc, 1);
  endtask

  task automatic t_rx_off;
    logic acc;
    wr(2'd3, 8'h02);
    send(STA, acc, "R13"); chk("R13 rx disabled rejects match", acc, 0);
    send(BCAST, acc, "R13 bcast"); chk("R13 rx disabled rejects broadcast", acc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_busy;
    t_station;
    t_ignore;
    t_wrap;
    t_hash;
    t_promisc;
    t_sof_restart;
    t_rx_off;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule